// File: doc/BRIEF.md
# Floppy Drive Power and Motor Sequencer

This block drives the control lines of a single floppy drive: the power switch enable, the drive select, the spindle motor enable, the spindle speed select and the write gate. It takes a suspend flag from the host-side power logic and select, motor, write and 360 RPM requests from the controller firmware. It also reads two sense lines from the drive: ready and write-protect, both active low. All outputs to the drive are active low and registered.

Drive power follows suspend. While the device is not suspended, the power enable line is held low. A select request asserts drive select. The motor may start only after the drive, once selected, reports ready. A drive that has no ready line ties that input low, and its motor then starts right after selection. If ready does not come within a programmable number of cycles, an error flag is raised and the motor stays off. Write requests are refused while the medium is write-protected. The write gate opens one cycle ahead of the write data path, and only while the motor is running.

Top module: `drive_pwr_seq`

## Requirements
- R1: `pwr_en_n_o` takes the value `suspend_i` had at the previous rising clock edge, so power is enabled (low) one cycle after suspend is cleared.
- R2: `sel_n_o` is low one cycle after a cycle with `sel_req_i`=1 and `suspend_i`=0, and high otherwise.
- R3: `rdy_n_i` passes through a two-stage synchronizer. After selection, `mtr_n_o` goes low only once the synchronized ready is low. A ready low applied just after edge k turns the motor on at edge k+3, and not before.
- R4: With `rdy_n_i` held low, `mtr_n_o` goes low at the second edge after the first edge that samples `sel_req_i`=1 with `mtr_req_i`=1.
- R5: A wait for ready begins at the first edge that samples a select, with the timeout limit L taken from `ready_limit_i`. If no ready arrives, `rdy_err_o` rises at edge L+2 and the motor stays off even if ready appears later. Removing the select clears `rdy_err_o` at the next edge.
- R6: `spd_n_o` is low, which selects 360 RPM, one cycle after a cycle with `fast_spin_i`=1, and high otherwise.
- R7: `wgate_n_o` goes low one cycle after a cycle with `wr_req_i`=1 while the motor is on (or turning on at that edge) and the medium is not protected.
- R8: While the synchronized `wp_n_i` is low, `wgate_n_o` stays high whatever `wr_req_i` does.
- R9: The edge that registers `suspend_i`=1 drives `pwr_en_n_o`, `sel_n_o`, `mtr_n_o` and `wgate_n_o` high together.
- R10: During synchronous reset every active-low output is high and `rdy_err_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| suspend_i | input | 1 | Device suspended |
| sel_req_i | input | 1 | Request to select the drive |
| mtr_req_i | input | 1 | Request to run the spindle |
| wr_req_i | input | 1 | Request to open the write gate |
| fast_spin_i | input | 1 | Request 360 RPM spindle speed |
| rdy_n_i | input | 1 | Drive ready sense, active low, asynchronous |
| wp_n_i | input | 1 | Write-protect sense, active low, asynchronous |
| ready_limit_i | input | CNT_W | Cycles allowed for ready after selection |
| pwr_en_n_o | output | 1 | Drive power switch enable, active low |
| sel_n_o | output | 1 | Drive select, active low |
| mtr_n_o | output | 1 | Motor on, active low |
| spd_n_o | output | 1 | Spindle speed select, low for 360 RPM |
| wgate_n_o | output | 1 | Write gate, active low |
| rdy_err_o | output | 1 | Ready timeout error |

## Verification
Power, select, speed and write gate respond one edge after the request that drives them. The motor needs at least two edges after selection, and a ready edge needs three edges to pass the synchronizer and the sequencer. The error flag rises at edge L+2 after selection. The bench's reference model advances one step per rising edge with the same latencies and compares all six outputs at each falling edge. Each directed check waits a counted number of falling edges after its stimulus, so it samples exactly in the cycle its result is due and also in the cycle before, to confirm the result does not appear early.

// File: rtl/dps_pkg.sv
package dps_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_RUN   = 2'd2,
    ST_FAULT = 2'd3
  } seq_st_t;
endpackage

// File: rtl/dps_sync.sv
module dps_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] pipe [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [WIDTH-1:0] src;
    if (g == 0) begin : g_first
      assign src = d;
    end else begin : g_next
      assign src = pipe[g-1];
    end
    always_ff @(posedge clk) begin
      if (rst) pipe[g] <= RST_VAL;
      else     pipe[g] <= src;
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/dps_ready_seq.sv
module dps_ready_seq
  import dps_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active_i,
  input  logic             ready_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             run_nxt_o,
  output logic             fault_o
);
  seq_st_t          state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (!active_i) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          state_d = ST_WAIT;
          cnt_d   = '0;
        end
        ST_WAIT: begin
          if (ready_i)               state_d = ST_RUN;
          else if (cnt_q >= limit_i) state_d = ST_FAULT;
          else                       cnt_d   = cnt_q + CNT_W'(1);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      fault_o <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      fault_o <= (state_d == ST_FAULT);
    end
  end

  assign run_nxt_o = (state_d == ST_RUN);

  // R5
  fault_from_wait_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fault_o) |-> ($past(state_q) == ST_WAIT));

  // R3
  run_from_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && $past(state_q) != ST_RUN) |-> ($past(state_q) == ST_WAIT && $past(ready_i)));
endmodule

// File: rtl/dps_wgate.sv
module dps_wgate (
  input  logic clk,
  input  logic rst,
  input  logic run_nxt_i,
  input  logic mtr_req_i,
  input  logic wr_req_i,
  input  logic prot_i,
  output logic wgate_n_o
);
  always_ff @(posedge clk) begin
    if (rst) wgate_n_o <= 1'b1;
    else     wgate_n_o <= !(wr_req_i && mtr_req_i && run_nxt_i && !prot_i);
  end

  // R8
  no_write_when_prot_chk: assert property (@(posedge clk) disable iff (rst)
    !wgate_n_o |-> !$past(prot_i));
endmodule

// File: rtl/drive_pwr_seq.sv
module drive_pwr_seq
  import dps_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             suspend_i,
  input  logic             sel_req_i,
  input  logic             mtr_req_i,
  input  logic             wr_req_i,
  input  logic             fast_spin_i,
  input  logic             rdy_n_i,
  input  logic             wp_n_i,
  input  logic [CNT_W-1:0] ready_limit_i,
  output logic             pwr_en_n_o,
  output logic             sel_n_o,
  output logic             mtr_n_o,
  output logic             spd_n_o,
  output logic             wgate_n_o,
  output logic             rdy_err_o
);
  localparam int SENSE_W = 2;

  logic [SENSE_W-1:0] sense_s;
  logic               active, run_nxt;

  dps_sync #(.WIDTH(SENSE_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({wp_n_i, rdy_n_i}),
    .q   (sense_s)
  );

  assign active = sel_req_i && !suspend_i;

  dps_ready_seq #(.CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .active_i  (active),
    .ready_i   (!sense_s[0]),
    .limit_i   (ready_limit_i),
    .run_nxt_o (run_nxt),
    .fault_o   (rdy_err_o)
  );

  dps_wgate u_wg (
    .clk       (clk),
    .rst       (rst),
    .run_nxt_i (run_nxt),
    .mtr_req_i (mtr_req_i),
    .wr_req_i  (wr_req_i),
    .prot_i    (!sense_s[1]),
    .wgate_n_o (wgate_n_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pwr_en_n_o <= 1'b1;
      sel_n_o    <= 1'b1;
      mtr_n_o    <= 1'b1;
      spd_n_o    <= 1'b1;
    end else begin
      pwr_en_n_o <= suspend_i;
      sel_n_o    <= !active;
      mtr_n_o    <= !(mtr_req_i && run_nxt);
      spd_n_o    <= !fast_spin_i;
    end
  end

  // R9
  suspend_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    pwr_en_n_o |-> (sel_n_o && mtr_n_o && wgate_n_o));

  // R3
  motor_needs_sel_chk: assert property (@(posedge clk) disable iff (rst)
    !mtr_n_o |-> !sel_n_o);

  // R5
  motor_not_in_fault_chk: assert property (@(posedge clk) disable iff (rst)
    !mtr_n_o |-> !rdy_err_o);

  // R7
  gate_needs_motor_chk: assert property (@(posedge clk) disable iff (rst)
    !wgate_n_o |-> !mtr_n_o);

  // R10
  always @(posedge clk) begin
    if ($past(rst)) begin
      reset_idle_chk: assert (rdy_err_o == 1'b0);
    end
  end
endmodule

// File: tb/sim_drive_pwr_seq.sv
module sim_drive_pwr_seq;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic suspend = 1'b1, sel_req = 1'b0, mtr_req = 1'b0, wr_req = 1'b0, fast = 1'b0;
  logic rdy_n = 1'b0, wp_n = 1'b1;
  logic [CNT_W-1:0] lim = 16'd50;
  logic pwr_en_n, sel_n, mtr_n, spd_n, wgate_n, rdy_err;

  int compared = 0;
  int mismatched = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  drive_pwr_seq #(.CNT_W(CNT_W), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .suspend_i(suspend), .sel_req_i(sel_req),
    .mtr_req_i(mtr_req), .wr_req_i(wr_req), .fast_spin_i(fast),
    .rdy_n_i(rdy_n), .wp_n_i(wp_n), .ready_limit_i(lim),
    .pwr_en_n_o(pwr_en_n), .sel_n_o(sel_n), .mtr_n_o(mtr_n),
    .spd_n_o(spd_n), .wgate_n_o(wgate_n), .rdy_err_o(rdy_err)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model: phase 0 idle, 1 waiting, 2 running, 3 fault
  bit r1 = 1, r2 = 1, w1 = 1, w2 = 1;
  int phase = 0;
  int waited = 0;
  bit e_pwr = 1, e_sel = 1, e_mtr = 1, e_spd = 1, e_wg = 1, e_err = 0;

  always @(posedge clk) begin
    int np;
    int nw;
    bit on;
    if (rst) begin
      r1 = 1; r2 = 1; w1 = 1; w2 = 1; phase = 0; waited = 0;
      e_pwr = 1; e_sel = 1; e_mtr = 1; e_spd = 1; e_wg = 1; e_err = 0;
    end else begin
      on = sel_req && !suspend;
      np = phase;
      nw = waited;
      if (!on) begin
        np = 0; nw = 0;
      end else if (phase == 0) begin
        np = 1; nw = 0;
      end else if (phase == 1) begin
        if (!r2) np = 2;
        else if (waited >= int'(lim)) np = 3;
        else nw = waited + 1;
      end
      e_pwr = suspend;
      e_sel = !on;
      e_mtr = !(mtr_req && np == 2);
      e_spd = !fast;
      e_wg  = !(wr_req && mtr_req && np == 2 && w2);
      e_err = (np == 3);
      r2 = r1; r1 = rdy_n;
      w2 = w1; w1 = wp_n;
      phase = np; waited = nw;
    end
  end

  always @(negedge clk) begin
    chk("R1 pwr_en_n model", pwr_en_n, e_pwr);
    chk("R2 sel_n model", sel_n, e_sel);
    chk("R3 mtr_n model", mtr_n, e_mtr);
    chk("R6 spd_n model", spd_n, e_spd);
    chk("R7 wgate_n model", wgate_n, e_wg);
    chk("R5 rdy_err model", rdy_err, e_err);
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL R10 watchdog: actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    cyc(3);
    // R10 reset state
    chk("R10 reset pwr_en_n", pwr_en_n, 1'b1);
    chk("R10 reset sel_n", sel_n, 1'b1);
    chk("R10 reset mtr_n", mtr_n, 1'b1);
    chk("R10 reset wgate_n", wgate_n, 1'b1);
    chk("R10 reset rdy_err", rdy_err, 1'b0);
    rst = 1'b0;
    cyc(1);
    chk("R1 still suspended", pwr_en_n, 1'b1);
    suspend = 1'b0;
    cyc(1);
    chk("R1 power on", pwr_en_n, 1'b0);
    cyc(3);

    // R4 ready tied low
    sel_req = 1'b1; mtr_req = 1'b1;
    cyc(1);
    chk("R2 select", sel_n, 1'b0);
    chk("R4 motor not yet", mtr_n, 1'b1);
    cyc(1);
    chk("R4 motor on", mtr_n, 1'b0);

    // R7 write gate
    wr_req = 1'b1;
    cyc(1);
    chk("R7 write gate open", wgate_n, 1'b0);
    wr_req = 1'b0;
    cyc(1);
    chk("R7 write gate closed", wgate_n, 1'b1);

    // R8 write protect
    wp_n = 1'b0;
    cyc(3);
    wr_req = 1'b1;
    cyc(1);
    chk("R8 protected gate", wgate_n, 1'b1);
    cyc(2);
    chk("R8 protected gate held", wgate_n, 1'b1);
    chk("R8 motor unaffected", mtr_n, 1'b0);
    wr_req = 1'b0; wp_n = 1'b1;
    cyc(3);

    // R6 speed
    fast = 1'b1;
    cyc(1);
    chk("R6 fast spin", spd_n, 1'b0);
    fast = 1'b0;
    cyc(1);
    chk("R6 normal spin", spd_n, 1'b1);

    // R9 suspend while writing
    wr_req = 1'b1;
    cyc(2);
    chk("R9 gate open before suspend", wgate_n, 1'b0);
    suspend = 1'b1;
    cyc(1);
    chk("R9 power off", pwr_en_n, 1'b1);
    chk("R9 select off", sel_n, 1'b1);
    chk("R9 motor off", mtr_n, 1'b1);
    chk("R9 gate off", wgate_n, 1'b1);
    suspend = 1'b0; wr_req = 1'b0; sel_req = 1'b0;
    rdy_n = 1'b1;
    cyc(4);

    // R3 ready handshake through synchronizer
    lim = 16'd20;
    sel_req = 1'b1;
    cyc(2);
    rdy_n = 1'b0;
    cyc(2);
    chk("R3 motor waits for synced ready", mtr_n, 1'b1);
    cyc(1);
    chk("R3 motor on after ready", mtr_n, 1'b0);
    sel_req = 1'b0; rdy_n = 1'b1;
    cyc(4);

    // R5 timeout with limit 5
    lim = 16'd5;
    sel_req = 1'b1;
    cyc(6);
    chk("R5 no error before limit", rdy_err, 1'b0);
    cyc(1);
    chk("R5 error at limit", rdy_err, 1'b1);
    chk("R5 motor off on error", mtr_n, 1'b1);
    rdy_n = 1'b0;
    cyc(4);
    chk("R5 late ready ignored", mtr_n, 1'b1);
    sel_req = 1'b0;
    cyc(1);
    chk("R5 error cleared", rdy_err, 1'b0);
    rdy_n = 1'b1;
    cyc(4);

    // R5 limit zero
    lim = 16'd0;
    sel_req = 1'b1;
    cyc(1);
    chk("R5 zero limit no error yet", rdy_err, 1'b0);
    cyc(1);
    chk("R5 zero limit error", rdy_err, 1'b1);
    sel_req = 1'b0;
    cyc(2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule